// File: doc/BRIEF.md
# Dual Window Monitor for Conversion Results

This block watches the stream of conversion results coming out of a multi-channel converter and checks two adjacent channels against programmable windows. One 4-bit field picks a base channel. Watchdog A follows that channel and watchdog B follows the channel numbered one above it. Each watchdog has its own 10-bit upper bound and its own 10-bit lower bound, which gives four bounds in all.

Each time a valid result arrives for a watched channel, it is compared against that watchdog's two bounds. An excursion above the upper bound or below the lower bound sets a sticky flag, one flag per watchdog and per bound. Each flag stays set until software clears it by writing a one to the matching clear bit. The interrupt request is the OR of the four flags, gated by an enable input. Because monitoring works on every result with no software involved, a controller can leave channels converting continuously and act only when a flag is raised.

Top module: `adc_window_watch`

## Requirements
- R1: While `rst` is high at a clock edge, `flags` becomes 4'b0000 after that edge, so `irq` is low.
- R2: A valid result on channel `pair_base` that is greater than `thr_a_hi` sets `flags[0]` (A-high) at the next clock edge.
- R3: A valid result on channel `pair_base` that is less than `thr_a_lo` sets `flags[1]` (A-low) at the next clock edge.
- R4: The comparisons are strict. A result equal to a bound sets no flag.
- R5: A valid result on channel `pair_base`+1 is compared only with `thr_b_hi` and `thr_b_lo`. Above the upper bound it sets `flags[2]` (B-high); below the lower bound it sets `flags[3]` (B-low).
- R6: When `pair_base` is 15, watchdog B is disabled. The channel number does not wrap, so a result on channel 0 sets no flag.
- R7: A result on a channel outside the watched pair sets no flag. A result presented with `res_valid` low also sets no flag.
- R8: A set flag stays set until a clock edge at which its bit of `flag_clr` is 1. Bits of `flag_clr` that are 0 leave their flags unchanged.
- R9: If a flag's set condition and its clear bit occur in the same cycle, the flag is set after the edge.
- R10: `irq` is 1 in the same cycle that `irq_en` is 1 and at least one flag is set; otherwise `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Strobe that marks a new conversion result |
| res_chan | input | 4 | Channel number of the result |
| res_data | input | 10 | Converted value |
| pair_base | input | 4 | Base channel of the watched pair |
| thr_a_hi | input | 10 | Upper bound for watchdog A |
| thr_a_lo | input | 10 | Lower bound for watchdog A |
| thr_b_hi | input | 10 | Upper bound for watchdog B |
| thr_b_lo | input | 10 | Lower bound for watchdog B |
| flag_clr | input | 4 | Per-flag clear: writing 1 clears that flag |
| irq_en | input | 1 | Interrupt enable |
| flags | output | 4 | Sticky flags: [0] A-high, [1] A-low, [2] B-high, [3] B-low |
| irq | output | 1 | Interrupt request |

## Verification
The table of results includes values that sit exactly on each bound and values one code beyond it. These separate the strict comparison from an inclusive one. Some results fall inside B's window but outside A's, which shows whether each watchdog uses its own bound pair. Other results arrive on a neighbouring unwatched channel or on channel 0 while the base is 15, which exposes a wrong channel decode or a wraparound. Directed cases then exercise a partial clear, a clear in the same cycle as a new hit, a result held with the strobe low, and interrupt gating with the enable both off and on.

// File: rtl/awatch_pkg.sv
package awatch_pkg;

    localparam int CHAN_W = 4;
    localparam int DATA_W = 10;
    localparam int N_WATCH = 2;
    localparam int N_FLAG = 2 * N_WATCH;

    // Outcome of one window comparison
    typedef struct packed {
        logic below;
        logic above;
    } win_hit_t;

    // Strict window test: bound values themselves pass
    function automatic win_hit_t win_test(
        input logic [DATA_W-1:0] value,
        input logic [DATA_W-1:0] upper,
        input logic [DATA_W-1:0] lower
    );
        win_hit_t r;
        r.above = value > upper;
        r.below = value < lower;
        return r;
    endfunction

endpackage

// File: rtl/awatch_cmp.sv
module awatch_cmp
    import awatch_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] value,
    input  logic [DW-1:0] upper,
    input  logic [DW-1:0] lower,
    output win_hit_t      hit
);

    win_hit_t raw;

    always_comb begin
        raw = win_test(value, upper, lower);
        hit = en ? raw : '0;
    end

    // R4
    upper_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (value == upper) |-> !hit.above);

    // R4
    lower_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (value == lower) |-> !hit.below);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> (hit == '0));

endmodule

// File: rtl/awatch_sticky.sv
module awatch_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr) | set;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (q == '0));

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & $past(q & ~clr)) == $past(q & ~clr)));

    // R7
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & ~$past(q) & ~$past(set)) == '0));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & $past(set)) == $past(set)));

endmodule

// File: rtl/adc_window_watch.sv
module adc_window_watch
    import awatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              res_valid,
    input  logic [CHAN_W-1:0] res_chan,
    input  logic [DATA_W-1:0] res_data,
    input  logic [CHAN_W-1:0] pair_base,
    input  logic [DATA_W-1:0] thr_a_hi,
    input  logic [DATA_W-1:0] thr_a_lo,
    input  logic [DATA_W-1:0] thr_b_hi,
    input  logic [DATA_W-1:0] thr_b_lo,
    input  logic [N_FLAG-1:0] flag_clr,
    input  logic              irq_en,
    output logic [N_FLAG-1:0] flags,
    output logic              irq
);

    logic [DATA_W-1:0] upper_bank [N_WATCH];
    logic [DATA_W-1:0] lower_bank [N_WATCH];
    win_hit_t          hits       [N_WATCH];
    logic [N_WATCH-1:0] watch_en;
    logic [N_FLAG-1:0] set_vec;

    assign upper_bank[0] = thr_a_hi;
    assign lower_bank[0] = thr_a_lo;
    assign upper_bank[1] = thr_b_hi;
    assign lower_bank[1] = thr_b_lo;

    for (genvar w = 0; w < N_WATCH; w++) begin : g_watch
        logic [CHAN_W:0] target;
        assign target = {1'b0, pair_base} + (CHAN_W+1)'(w);
        // a target past the last channel does not wrap
        assign watch_en[w] = res_valid && !target[CHAN_W]
                             && (target[CHAN_W-1:0] == res_chan);

        awatch_cmp #(.DW(DATA_W)) u_cmp (
            .clk   (clk),
            .rst   (rst),
            .en    (watch_en[w]),
            .value (res_data),
            .upper (upper_bank[w]),
            .lower (lower_bank[w]),
            .hit   (hits[w])
        );

        assign set_vec[2*w]   = hits[w].above;
        assign set_vec[2*w+1] = hits[w].below;
    end

    awatch_sticky #(.N(N_FLAG)) u_flags (
        .clk (clk),
        .rst (rst),
        .set (set_vec),
        .clr (flag_clr),
        .q   (flags)
    );

    assign irq = irq_en && (|flags);

    // R6
    top_b_off_chk: assert property (@(posedge clk) disable iff (rst)
        (pair_base == '1) |-> !watch_en[1]);

    // R5
    pair_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(watch_en[0] && watch_en[1]));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

endmodule

// File: tb/adc_window_watch_tb.sv
`timescale 1ns/1ps
module adc_window_watch_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       res_valid = 1'b0;
    logic [3:0] res_chan = '0;
    logic [9:0] res_data = '0;
    logic [3:0] pair_base = '0;
    logic [9:0] thr_a_hi = 10'd600;
    logic [9:0] thr_a_lo = 10'd200;
    logic [9:0] thr_b_hi = 10'd800;
    logic [9:0] thr_b_lo = 10'd100;
    logic [3:0] flag_clr = '0;
    logic       irq_en = 1'b0;
    logic [3:0] flags;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    adc_window_watch u_dut (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_chan(res_chan),
        .res_data(res_data), .pair_base(pair_base), .thr_a_hi(thr_a_hi),
        .thr_a_lo(thr_a_lo), .thr_b_hi(thr_b_hi), .thr_b_lo(thr_b_lo),
        .flag_clr(flag_clr), .irq_en(irq_en), .flags(flags), .irq(irq)
    );

    // {base, chan, data, expected flags}; A window 200..600, B window 100..800
    localparam logic [21:0] VEC [12] = '{
        {4'd3,  4'd3,  10'd601,  4'b0001},  // R2
        {4'd3,  4'd3,  10'd600,  4'b0000},  // R4
        {4'd3,  4'd3,  10'd199,  4'b0010},  // R3
        {4'd3,  4'd3,  10'd200,  4'b0000},  // R4
        {4'd3,  4'd4,  10'd801,  4'b0100},  // R5
        {4'd3,  4'd4,  10'd99,   4'b1000},  // R5
        {4'd3,  4'd4,  10'd700,  4'b0000},  // R5
        {4'd3,  4'd5,  10'd1000, 4'b0000},  // R7
        {4'd15, 4'd15, 10'd1023, 4'b0001},  // R2
        {4'd15, 4'd0,  10'd1023, 4'b0000},  // R6
        {4'd15, 4'd0,  10'd0,    4'b0000},  // R6
        {4'd0,  4'd1,  10'd0,    4'b1000}   // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk) flag_clr = 4'hF;
        @(negedge clk) flag_clr = 4'h0;
    endtask

    task automatic run();
        repeat (2) @(negedge clk);
        check("R1", {28'd0, flags}, 32'd0);
        check("R1", {31'd0, irq}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            pair_base = VEC[i][21:18];
            res_chan  = VEC[i][17:14];
            res_data  = VEC[i][13:4];
            res_valid = 1'b1;
            @(negedge clk);
            res_valid = 1'b0;
            check($sformatf("R2-table row %0d (R3 R4 R5 R6 R7)", i), {28'd0, flags}, {28'd0, VEC[i][3:0]});
            clear_all();
        end

        // R7: value held with strobe low
        pair_base = 4'd3; res_chan = 4'd3; res_data = 10'd1023;
        repeat (2) @(negedge clk);
        check("R7 strobe low", {28'd0, flags}, 32'd0);

        // R8: sticky flags with partial clear
        res_valid = 1'b1;
        @(negedge clk) begin res_chan = 4'd4; res_data = 10'd5; end
        @(negedge clk) res_valid = 1'b0;
        check("R8 both set", {28'd0, flags}, 32'b1001);
        repeat (3) @(negedge clk);
        check("R8 hold", {28'd0, flags}, 32'b1001);
        flag_clr = 4'b0001;
        @(negedge clk) flag_clr = 4'b0000;
        check("R8 partial clear", {28'd0, flags}, 32'b1000);

        // R10: interrupt gating
        irq_en = 1'b0; #0.5;
        check("R10 disabled", {31'd0, irq}, 32'd0);
        irq_en = 1'b1; #0.5;
        check("R10 enabled", {31'd0, irq}, 32'd1);
        clear_all();
        check("R10 no flags", {31'd0, irq}, 32'd0);

        // R9: set and clear in the same cycle
        @(negedge clk);
        res_chan = 4'd3; res_data = 10'd900; res_valid = 1'b1; flag_clr = 4'b0001;
        @(negedge clk);
        res_valid = 1'b0; flag_clr = 4'b0000;
        check("R9 set wins", {28'd0, flags}, 32'b0001);
        check("R10 follows flag", {31'd0, irq}, 32'd1);

        // R1: reset clears a set flag
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears", {28'd0, flags}, 32'd0);
        rst = 1'b0;
    endtask

    initial begin
        fork
            run();
            begin
                repeat (200000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule